// File: doc/BRIEF.md
# Pipelined Bus Slave with Programmable Wait States

This block is a storage-backed target on a pipelined single-target bus. Address and control arrive in one cycle (the address phase) and the matching data moves in a later cycle (the data phase). The block captures address and control only on a clock edge where the bus ready input is high. In the following data phase it carries out the read or write on a small internal file of 32-bit words. A real transfer's data phase can be stretched by 0 to 3 wait states, which the block signals by holding its ready output low.

The two-bit transfer kind selects whether a data phase does anything. Idle (00) and busy (01) cycles complete at once and touch nothing. Non-sequential (10) and sequential (11) beats both perform a transfer with the configured stretch. A single access is a one-beat burst that starts with a non-sequential beat. The response is always OKAY. Byte and halfword writes update only the lanes they select.

Top module: `pipe_wait_slave`

## Requirements
- R1: After reset the ready output is high, the response is OKAY (0) and the read data output is zero.
- R2: An idle (00) or busy (01) cycle captured in an address phase gives a data phase with ready high at once. It changes no stored word, even when the write control and write data are set.
- R3: A non-sequential or sequential beat captured with a wait setting of N (0..3) holds ready low for exactly N cycles of its data phase. Ready is high in the cycle after those N cycles.
- R4: A write stores the write data present in the data-phase cycle in which ready is high. Values present during the earlier stretched cycles have no effect.
- R5: A read presents the addressed word on the read data output in the data-phase cycle in which ready is high. In every other cycle the output is zero.
- R6: Address and control are sampled only on edges where the ready input is high. A transfer presented only while ready is low never takes place.
- R7: The word index is address bits [5:2]. Address bits above bit 5 are ignored, so addresses 64 bytes apart reach the same word.
- R8: Size code 0 (byte) writes only the lane given by address bits [1:0]. Size code 1 (halfword) writes lanes 0-1 or 2-3, chosen by address bit 1. Size code 2 writes all four lanes. Lane k is data bits [8k+7:8k].
- R9: The response output is OKAY (0) in every cycle.
- R10: A sequential (11) beat performs its read or write exactly as a non-sequential beat does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_kind | input | 2 | Transfer kind: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| xfer_addr | input | 32 | Byte address of the address phase |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 3 | Size code: 0 byte, 1 halfword, 2 word |
| wr_data | input | 32 | Write data, used in the data phase |
| rdy_in | input | 1 | Bus ready, high when the current data phase completes |
| wait_cfg | input | 2 | Wait states for each real transfer |
| rd_data | output | 32 | Read data, valid in the cycle where rdy_out is high |
| rdy_out | output | 1 | Ready from this target, low while it stretches a data phase |
| resp | output | 1 | Response, 0 = OKAY |

## Verification
The bench builds the block with its default parameters: 16 words, 32-bit data and a 2-bit wait setting. The full wait range 0 to 3 can therefore be reached, and an address 64 bytes higher lands on the same word, which exercises the aliasing rule. It drives the ready input from the block's own ready output, as a single-target bus would. This lets it present a stray transfer during stretched cycles and then confirm through read-back that the transfer was never taken.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'b00,
    KIND_BUSY = 2'b01,
    KIND_NSEQ = 2'b10,
    KIND_SEQ  = 2'b11
  } kind_e;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;

  localparam logic RESP_OKAY = 1'b0;

  // A kind moves data only when its upper bit is set (non-sequential or sequential)
  function automatic logic moves_data(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/pws_phase_reg.sv
module pws_phase_reg
  import pws_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int BOFF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_in,
  input  logic [1:0]        kind,
  input  logic [IDX_W+BOFF-1:0] addr_lo,
  input  logic              write,
  input  logic [2:0]        size,
  output logic              dp_act,
  output logic [IDX_W-1:0]  dp_idx,
  output logic [BOFF-1:0]   dp_off,
  output logic              dp_write,
  output logic [2:0]        dp_size
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_act   <= 1'b0;
      dp_idx   <= '0;
      dp_off   <= '0;
      dp_write <= 1'b0;
      dp_size  <= SZ_WORD;
    end else if (rdy_in) begin
      dp_act <= moves_data(kind);
      if (moves_data(kind)) begin
        dp_idx   <= addr_lo[BOFF +: IDX_W];
        dp_off   <= addr_lo[BOFF-1:0];
        dp_write <= write;
        dp_size  <= size;
      end
    end
  end

endmodule

// File: rtl/pws_wait_ctr.sv
module pws_wait_ctr #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_in,
  input  logic              start,
  input  logic [WAIT_W-1:0] cfg,
  output logic              expired
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (rdy_in) begin
      cnt <= start ? cfg : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - WAIT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pws_regfile.sv
module pws_regfile #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem[w][8*l +: 8] <= '0;
        end else if (we && lane_en[l] && (idx == IDX_W'(w))) begin
          mem[w][8*l +: 8] <= wdata[8*l +: 8];
        end
      end
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/pipe_wait_slave.sv
module pipe_wait_slave
  import pws_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xfer_kind,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_write,
  input  logic [2:0]        xfer_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rdy_in,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy_out,
  output logic              resp
);

  localparam int LANES = DATA_W / 8;
  localparam int BOFF  = $clog2(LANES);
  localparam int IDX_W = $clog2(WORDS);
  localparam int LO_W  = IDX_W + BOFF;

  // Lanes touched by an access of size code sz at byte offset off
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz,
                                                 input logic [BOFF-1:0] off);
    logic [LANES-1:0] m;
    int nb;
    int base;
    nb = 1 << sz;
    if (nb > LANES) nb = LANES;
    base = int'(off) & ~(nb - 1);
    for (int l = 0; l < LANES; l++) m[l] = (l >= base) && (l < base + nb);
    return m;
  endfunction

  logic              unused_hi;
  assign unused_hi = ^xfer_addr[ADDR_W-1:LO_W];

  logic              dp_act;
  logic [IDX_W-1:0]  dp_idx;
  logic [BOFF-1:0]   dp_off;
  logic              dp_write;
  logic [2:0]        dp_size;
  logic              wait_done;
  logic              write_fire;
  logic              read_fire;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] store_word;

  pws_phase_reg #(.IDX_W(IDX_W), .BOFF(BOFF)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_in   (rdy_in),
    .kind     (xfer_kind),
    .addr_lo  (xfer_addr[LO_W-1:0]),
    .write    (xfer_write),
    .size     (xfer_size),
    .dp_act   (dp_act),
    .dp_idx   (dp_idx),
    .dp_off   (dp_off),
    .dp_write (dp_write),
    .dp_size  (dp_size)
  );

  pws_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_in  (rdy_in),
    .start   (moves_data(xfer_kind)),
    .cfg     (wait_cfg),
    .expired (wait_done)
  );

  // Named events for the checker
  assign write_fire = dp_act &  dp_write & wait_done;
  assign read_fire  = dp_act & ~dp_write & wait_done;
  assign lane_en    = lane_mask(dp_size, dp_off);

  pws_regfile #(.WORDS(WORDS), .DATA_W(DATA_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (write_fire),
    .idx     (dp_idx),
    .lane_en (lane_en),
    .wdata   (wr_data),
    .rdata   (store_word)
  );

  assign rdy_out = ~dp_act | wait_done;
  assign rd_data = read_fire ? store_word : '0;
  assign resp    = RESP_OKAY;

endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int WAIT_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        xfer_kind,
  input logic              rdy_in,
  input logic              rdy_out,
  input logic              resp,
  input logic [DATA_W-1:0] rd_data,
  input logic [WAIT_W-1:0] wait_cfg,
  input logic              write_fire,
  input logic              read_fire,
  input logic              dp_act
);

  localparam int MAXW = (1 << WAIT_W) - 1;

  // Consecutive cycles with ready low, bounded by the largest wait setting
  logic [WAIT_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (rdy_out) low_run <= '0;
    else              low_run <= low_run + 1'b1;
  end

  assert_okay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp == 1'b0) else $error("resp not OKAY");

  assert_idle_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_in && !xfer_kind[1] |=> rdy_out) else $error("idle/busy stretched");

  assert_idle_no_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_in && !xfer_kind[1] |=> !write_fire && !read_fire) else $error("idle/busy fired");

  assert_stretch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_in && xfer_kind[1] && wait_cfg != '0 |=> !rdy_out) else $error("missing wait");

  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_in && xfer_kind[1] && wait_cfg == '0 |=> rdy_out) else $error("spurious wait");

  assert_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_run) <= MAXW) else $error("stretch too long");

  assert_commit_on_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |-> rdy_in) else $error("write without ready");

  assert_quiet_rdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_out |-> rd_data == '0) else $error("read data while stretched");

  assert_hold_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_in |=> dp_act == $past(dp_act)) else $error("phase taken while not ready");

endmodule

bind pipe_wait_slave pws_checker #(.WAIT_W(WAIT_W), .DATA_W(DATA_W)) u_pws_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_kind  (xfer_kind),
  .rdy_in     (rdy_in),
  .rdy_out    (rdy_out),
  .resp       (resp),
  .rd_data    (rd_data),
  .wait_cfg   (wait_cfg),
  .write_fire (write_fire),
  .read_fire  (read_fire),
  .dp_act     (dp_act)
);

// File: tb/test_pipe_wait_slave.sv
module test_pipe_wait_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  xfer_kind = 2'b00;
  logic [31:0] xfer_addr = '0;
  logic        xfer_write = 1'b0;
  logic [2:0]  xfer_size = 3'd2;
  logic [31:0] wr_data = '0;
  logic [1:0]  wait_cfg = '0;
  logic [31:0] rd_data;
  logic        rdy_out;
  logic        resp;
  wire         rdy_in;

  assign rdy_in = rdy_out;

  always #10 clk = ~clk;

  pipe_wait_slave i_pipe_wait_slave (
    .clk(clk), .rst_n(rst_n), .xfer_kind(xfer_kind), .xfer_addr(xfer_addr),
    .xfer_write(xfer_write), .xfer_size(xfer_size), .wr_data(wr_data),
    .rdy_in(rdy_in), .wait_cfg(wait_cfg), .rd_data(rd_data),
    .rdy_out(rdy_out), .resp(resp)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mon_rd = 0;
  logic [31:0] model [16];
  logic [31:0] q_d[$];
  string       q_t[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data when a read completes
  always @(negedge clk) begin
    #1;
    if (mon_rd && rdy_out && q_d.size() != 0) begin
      logic [31:0] e;
      string t;
      e = q_d.pop_front();
      t = q_t.pop_front();
      check(rd_data == e, t, rd_data, e);
    end
  end

  // Bench's own lane rule: a byte is covered when it shares the access's aligned block
  task automatic model_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
    int w;
    w = int'(a[5:2]);
    for (int b = 0; b < 4; b++) begin
      bit hit;
      hit = (sz >= 3'd2) || ((b >> sz) == (int'(a[1:0]) >> sz));
      if (hit) model[w][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic xfer(input logic [1:0] k, input logic wr, input logic [31:0] a,
                      input logic [2:0] sz, input logic [31:0] wd, input int expw,
                      input bit stray, input string tag);
    int waits;
    @(negedge clk);
    mon_rd     = 0;
    xfer_kind  = k;
    xfer_addr  = a;
    xfer_write = wr;
    xfer_size  = sz;
    wr_data    = 32'hDEAD_BEEF;
    @(negedge clk);
    if (k[1] && wr) model_write(a, sz, wd);
    if (k[1] && !wr) begin
      q_d.push_back(model[a[5:2]]);
      q_t.push_back(tag);
      mon_rd = 1;
    end
    waits = 0;
    if (stray) begin
      xfer_kind  = 2'b10;
      xfer_write = 1'b1;
      xfer_addr  = 32'h0000_0014;
    end else begin
      xfer_kind = 2'b00;
    end
    while (!rdy_out && waits < 8) begin
      waits++;
      wr_data = 32'h5A5A_0000 | 32'(waits);
      @(negedge clk);
    end
    xfer_kind  = 2'b00;
    xfer_write = 1'b0;
    wr_data    = wd;
    check(waits == expw, {tag, " R3 wait count"}, 32'(waits), 32'(expw));
    check(resp == 1'b0, {tag, " R9 resp"}, 32'(resp), 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy_out == 1'b1, "R1 ready after reset", 32'(rdy_out), 32'h1);
    check(resp == 1'b0, "R1 resp after reset", 32'(resp), 32'h0);
    check(rd_data == '0, "R1 rdata after reset", rd_data, 32'h0);

    wait_cfg = 2'd0;
    xfer(2'b10, 1, 32'h0000_0000, 3'd2, 32'h1122_3344, 0, 0, "R4 zero-wait write");
    xfer(2'b10, 0, 32'h0000_0000, 3'd2, 32'h0, 0, 0, "R5 zero-wait read");

    wait_cfg = 2'd2;
    xfer(2'b10, 1, 32'h0000_0008, 3'd2, 32'hA5C3_0F96, 2, 0, "R4 stretched write");
    xfer(2'b10, 0, 32'h0000_0008, 3'd2, 32'h0, 2, 0, "R5 stretched read");
    wait_cfg = 2'd3;
    xfer(2'b10, 0, 32'h0000_0008, 3'd2, 32'h0, 3, 0, "R3 three-wait read");

    wait_cfg = 2'd1;
    xfer(2'b11, 1, 32'h0000_000C, 3'd2, 32'h0BAD_F00D, 1, 0, "R10 sequential write");
    xfer(2'b11, 0, 32'h0000_000C, 3'd2, 32'h0, 1, 0, "R10 sequential read");

    xfer(2'b00, 1, 32'h0000_0000, 3'd2, 32'hFFFF_FFFF, 0, 0, "R2 idle with write");
    xfer(2'b01, 1, 32'h0000_0000, 3'd2, 32'hEEEE_EEEE, 0, 0, "R2 busy with write");
    xfer(2'b10, 0, 32'h0000_0000, 3'd2, 32'h0, 1, 0, "R2 word untouched");

    wait_cfg = 2'd0;
    xfer(2'b10, 1, 32'h0000_0044, 3'd2, 32'h4444_0001, 0, 0, "R7 high write");
    xfer(2'b10, 0, 32'h0000_0004, 3'd2, 32'h0, 0, 0, "R7 alias read");
    xfer(2'b10, 1, 32'hFFFF_FFC8, 3'd2, 32'h7777_2222, 0, 0, "R7 top write");
    xfer(2'b10, 0, 32'h0000_0008, 3'd2, 32'h0, 0, 0, "R7 top alias read");

    xfer(2'b10, 1, 32'h0000_000C, 3'd2, 32'h0000_0000, 0, 0, "R8 clear");
    xfer(2'b10, 1, 32'h0000_000D, 3'd0, 32'h1234_AB78, 0, 0, "R8 byte write");
    xfer(2'b10, 1, 32'h0000_000E, 3'd1, 32'hCDEF_9999, 0, 0, "R8 half write");
    xfer(2'b10, 0, 32'h0000_000C, 3'd2, 32'h0, 0, 0, "R8 lanes read");
    xfer(2'b10, 1, 32'h0000_0018, 3'd2, 32'h0102_0304, 0, 0, "R8 word write");
    xfer(2'b10, 1, 32'h0000_0018, 3'd0, 32'hFFFF_FFAA, 0, 0, "R8 byte lane0");
    xfer(2'b10, 1, 32'h0000_0018, 3'd1, 32'hFFFF_BBCC, 0, 0, "R8 low half");
    xfer(2'b10, 0, 32'h0000_0018, 3'd2, 32'h0, 0, 0, "R8 low lanes read");

    wait_cfg = 2'd2;
    xfer(2'b10, 1, 32'h0000_0010, 3'd2, 32'h1010_1010, 2, 1, "R6 write with stray");
    xfer(2'b10, 0, 32'h0000_0014, 3'd2, 32'h0, 2, 0, "R6 stray word untouched");
    xfer(2'b10, 0, 32'h0000_0010, 3'd2, 32'h0, 2, 0, "R6 real word written");

    @(negedge clk);
    mon_rd = 0;
    check(q_d.size() == 0, "R5 scoreboard drained", 32'(q_d.size()), 32'h0);
    check(rd_data == '0, "R5 rdata idle", rd_data, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  end

endmodule